// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a virtual page to a real address by searching a hashed translation table held in memory. A request supplies the segment's virtual segment identifier, the effective address and a store flag. The block derives a hash from the identifier and the page index. It reads the eight entries of the primary group one at a time and, if none of them matches, reads the eight entries of the group selected by the complemented hash. All memory traffic goes through one 32-bit port with a valid/ready request channel and a separate read-response strobe.

On a hit the walker returns both words of the matching entry, the entry's byte offset from the table base, and the real address. Before it responds, it can mark the entry as referenced, and on a store also as changed. Each of these marks is a single-byte write, so no other byte of the entry is disturbed. Protection decisions are left to the caller. Pages are 4 KiB, entries are 8 bytes, and a group holds 8 entries (64 bytes).

Top module: `hpt_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0.
- R2: The page index is `req_ea[27:12]`. The primary hash is the 32-bit value `{8'h0,vsid} ^ {16'h0,page index}`. A group offset is `(hash << 6) & cfg_tbl_mask`. Entry k of a group has word 0 at byte `cfg_tbl_base + offset + 8k` and word 1 four bytes higher. The first read of a walk is word 0 of entry 0 of the primary group.
- R3: The secondary group uses the bitwise complement of the 32-bit primary hash. It is searched only after all 8 primary entries fail to match.
- R4: An entry matches when all three of these hold:
  - word 0 bit 31 (valid) is 1;
  - word 0 bit 6 equals the search kind (0 for primary, 1 for secondary);
  - `((word0 ^ tag) & 32'h7FFF_FFBF) == 0`, where `tag = ({8'h0,vsid} << 7) | req_ea[27:22]`.
- R5: Entries are searched in ascending order and the first match wins. Word 1 of an entry is read only after its word 0 has come back matching. An entry that does not match causes no word-1 read.
- R6: A hit responds with `rsp_hit`=1, both entry words, `rsp_off` equal to the entry's byte offset from the table base, and `rsp_raddr = {word1[31:12], req_ea[11:0]}`.
- R7: If word 1 bit 8 (referenced) is 0, the walker issues one byte write. The write goes to the word-1 address with `mem_req_wstrb`=4'b0010, and its lane 1 carries `word1[15:8] | 8'h01`. Lane k is `wdata[8k+7:8k]`.
- R8: On a store with word 1 bit 7 (changed) at 0, the walker issues one byte write to the word-1 address with strobe 4'b0001. Its lane 0 carries `word1[7:0] | 8'h80`. This write comes after the referenced write, if there is one. A load, or an entry whose bits are already set, causes no write.
- R9: When neither group matches, the walker responds after exactly 16 reads with `rsp_hit`=0 and writes nothing.
- R10: A request is taken only while `req_ready` is 1. `req_valid` during a walk is ignored and starts no later walk.
- R11: At most one read is outstanding: `mem_req_valid` stays low from an accepted read until its response. A request that is not accepted holds its address and kind.
- R12: `rsp_valid` is a one-cycle pulse, followed by `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request taken |
| req_vsid | input | 24 | Virtual segment identifier |
| req_ea | input | 32 | Effective address |
| req_store | input | 1 | Access is a store |
| cfg_tbl_base | input | 32 | Table base byte address |
| cfg_tbl_mask | input | 32 | Table offset mask |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | 32 | Word-aligned byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_req_wstrb | output | 4 | Byte-lane write enables |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Walk result pulse |
| rsp_hit | output | 1 | Entry found |
| rsp_w0 | output | 32 | Entry word 0 |
| rsp_w1 | output | 32 | Entry word 1 |
| rsp_off | output | 32 | Entry byte offset from base |
| rsp_raddr | output | 32 | Real address |

## Verification
The bench fills the primary group with near-misses: a wrong tag, the right tag with the secondary-kind bit set, and the right tag with the valid bit clear. A walker that ignored any one field of the compare would stop too early and report the wrong offset. A secondary-group hit with both status bits clear checks the hashed group address, the two byte writes and their order. A walker that wrote whole words or used the wrong lane would corrupt the stored word 1. A miss must take exactly sixteen word-0 reads and no word-1 read. Further walks cover these cases:
- a busy period with back-pressure and a competing request, which would otherwise cause a second walk or a lost address;
- a narrow mask on a non-zero base, which would expose a wrong mask or base combination.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  // Walk sequencing states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD0,
    ST_W0,
    ST_RD1,
    ST_W1,
    ST_WR_R,
    ST_WR_C,
    ST_DONE
  } walk_st_e;

  // Bit positions inside the entry words
  localparam int unsigned VALID_POS = 31;
  localparam int unsigned HSEL_POS  = 6;
  localparam int unsigned REF_POS   = 8;
  localparam int unsigned CHG_POS   = 7;

endpackage

// File: rtl/hpt_hash_calc.sv
module hpt_hash_calc #(
  parameter int AW        = 32,
  parameter int VSID_W    = 24,
  parameter int PIDX_W    = 16,
  parameter int API_W     = 6,
  parameter int GRP_SHIFT = 6
) (
  input  logic [VSID_W-1:0] vsid,
  input  logic [PIDX_W-1:0] pidx,
  input  logic              secondary,
  input  logic [AW-1:0]     tbl_base,
  input  logic [AW-1:0]     tbl_mask,
  output logic [AW-1:0]     grp_off,
  output logic [AW-1:0]     grp_addr,
  output logic [AW-1:0]     tag
);

  localparam int API_SHIFT = PIDX_W - API_W;

  logic [AW-1:0] hash;
  logic [AW-1:0] hsel;

  always_comb begin
    hash     = AW'(vsid) ^ AW'(pidx);
    hsel     = secondary ? ~hash : hash;
    grp_off  = (hsel << GRP_SHIFT) & tbl_mask;
    grp_addr = tbl_base + grp_off;
    tag      = (AW'(vsid) << (API_W + 1)) | AW'(pidx >> API_SHIFT);
  end

endmodule

// File: rtl/hpt_entry_match.sv
module hpt_entry_match #(
  parameter int AW     = 32,
  parameter int V_POS  = 31,
  parameter int H_POS  = 6
) (
  input  logic [AW-1:0] w0,
  input  logic [AW-1:0] tag,
  input  logic          secondary,
  output logic          hit
);

  localparam logic [AW-1:0] CMP_MASK = ~((AW'(1) << V_POS) | (AW'(1) << H_POS));

  always_comb begin
    hit = w0[V_POS] && (w0[H_POS] == secondary) && (((w0 ^ tag) & CMP_MASK) == '0);
  end

endmodule

// File: rtl/hpt_wb_gen.sv
module hpt_wb_gen #(
  parameter int AW      = 32,
  parameter int LANES   = AW / 8,
  parameter int REF_BIT = 8,
  parameter int CHG_BIT = 7
) (
  input  logic [AW-1:0]    w1,
  input  logic             sel_chg,
  output logic [AW-1:0]    wdata,
  output logic [LANES-1:0] wstrb
);

  localparam int REF_LANE = REF_BIT / 8;
  localparam int CHG_LANE = CHG_BIT / 8;

  // Each status mark touches only the byte lane holding its bit.
  always_comb begin
    wdata = w1;
    wstrb = '0;
    if (sel_chg) begin
      wstrb[CHG_LANE] = 1'b1;
      wdata[CHG_BIT]  = 1'b1;
    end else begin
      wstrb[REF_LANE] = 1'b1;
      wdata[REF_BIT]  = 1'b1;
    end
  end

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int AW            = 32,
  parameter int VSID_W        = 24,
  parameter int SEG_BITS      = 28,
  parameter int PAGE_BITS     = 12,
  parameter int API_W         = 6,
  parameter int ENTRY_BYTES   = 8,
  parameter int GROUP_ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VSID_W-1:0] req_vsid,
  input  logic [AW-1:0]     req_ea,
  input  logic              req_store,
  input  logic [AW-1:0]     cfg_tbl_base,
  input  logic [AW-1:0]     cfg_tbl_mask,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [AW-1:0]     mem_req_addr,
  output logic [AW-1:0]     mem_req_wdata,
  output logic [AW/8-1:0]   mem_req_wstrb,
  input  logic              mem_rsp_valid,
  input  logic [AW-1:0]     mem_rsp_rdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [AW-1:0]     rsp_w0,
  output logic [AW-1:0]     rsp_w1,
  output logic [AW-1:0]     rsp_off,
  output logic [AW-1:0]     rsp_raddr
);

  localparam int PIDX_W     = SEG_BITS - PAGE_BITS;
  localparam int IDX_W      = $clog2(GROUP_ENTRIES);
  localparam int ENT_SHIFT  = $clog2(ENTRY_BYTES);
  localparam int GRP_SHIFT  = $clog2(ENTRY_BYTES * GROUP_ENTRIES);
  localparam int WORD_BYTES = AW / 8;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(GROUP_ENTRIES - 1);

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // State and captured request
  walk_st_e            st_q, st_d;
  logic                sec_q, sec_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic                hit_q, hit_d;
  logic [VSID_W-1:0]   vsid_q;
  logic [PIDX_W-1:0]   pidx_q;
  logic [PAGE_BITS-1:0] pofs_q;
  logic                store_q;
  logic [AW-1:0]       w0_q, w1_q;
  logic                cap_req, cap_w0, cap_w1;

  logic unused_ea_hi;
  assign unused_ea_hi = ^req_ea[AW-1:SEG_BITS];

  // Address and compare datapath
  logic [AW-1:0] grp_off, grp_addr, tag;
  logic [AW-1:0] ent_off, ent_addr;
  logic          ent_hit;
  logic [AW-1:0] wb_data;
  logic [WORD_BYTES-1:0] wb_strb;

  hpt_hash_calc #(
    .AW(AW), .VSID_W(VSID_W), .PIDX_W(PIDX_W), .API_W(API_W), .GRP_SHIFT(GRP_SHIFT)
  ) u_hash (
    .vsid(vsid_q), .pidx(pidx_q), .secondary(sec_q),
    .tbl_base(cfg_tbl_base), .tbl_mask(cfg_tbl_mask),
    .grp_off(grp_off), .grp_addr(grp_addr), .tag(tag)
  );

  hpt_entry_match #(
    .AW(AW), .V_POS(VALID_POS), .H_POS(HSEL_POS)
  ) u_match (
    .w0(mem_rsp_rdata), .tag(tag), .secondary(sec_q), .hit(ent_hit)
  );

  hpt_wb_gen #(
    .AW(AW), .LANES(WORD_BYTES), .REF_BIT(REF_POS), .CHG_BIT(CHG_POS)
  ) u_wb (
    .w1(w1_q), .sel_chg(st_q == ST_WR_C), .wdata(wb_data), .wstrb(wb_strb)
  );

  assign ent_off  = grp_off + (AW'(idx_q) << ENT_SHIFT);
  assign ent_addr = grp_addr + (AW'(idx_q) << ENT_SHIFT);

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    sec_d   = sec_q;
    idx_d   = idx_q;
    hit_d   = hit_q;
    cap_req = 1'b0;
    cap_w0  = 1'b0;
    cap_w1  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_req = 1'b1;
          sec_d   = 1'b0;
          idx_d   = '0;
          hit_d   = 1'b0;
          st_d    = ST_RD0;
        end
      end
      ST_RD0: if (mem_req_ready) st_d = ST_W0;
      ST_W0: begin
        if (mem_rsp_valid) begin
          if (ent_hit) begin
            cap_w0 = 1'b1;
            st_d   = ST_RD1;
          end else if (idx_q == IDX_LAST) begin
            if (sec_q) begin
              st_d = ST_DONE;
            end else begin
              sec_d = 1'b1;
              idx_d = '0;
              st_d  = ST_RD0;
            end
          end else begin
            idx_d = idx_q + 1'b1;
            st_d  = ST_RD0;
          end
        end
      end
      ST_RD1: if (mem_req_ready) st_d = ST_W1;
      ST_W1: begin
        if (mem_rsp_valid) begin
          cap_w1 = 1'b1;
          hit_d  = 1'b1;
          if (!mem_rsp_rdata[REF_POS])                   st_d = ST_WR_R;
          else if (store_q && !mem_rsp_rdata[CHG_POS])   st_d = ST_WR_C;
          else                                           st_d = ST_DONE;
        end
      end
      ST_WR_R: begin
        if (mem_req_ready) st_d = (store_q && !w1_q[CHG_POS]) ? ST_WR_C : ST_DONE;
      end
      ST_WR_C: if (mem_req_ready) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q    <= ST_IDLE;
      sec_q   <= 1'b0;
      idx_q   <= '0;
      hit_q   <= 1'b0;
      vsid_q  <= '0;
      pidx_q  <= '0;
      pofs_q  <= '0;
      store_q <= 1'b0;
      w0_q    <= '0;
      w1_q    <= '0;
    end else begin
      st_q  <= st_d;
      sec_q <= sec_d;
      idx_q <= idx_d;
      hit_q <= hit_d;
      if (cap_req) begin
        vsid_q  <= req_vsid;
        pidx_q  <= req_ea[SEG_BITS-1:PAGE_BITS];
        pofs_q  <= req_ea[PAGE_BITS-1:0];
        store_q <= req_store;
      end
      if (cap_w0) w0_q <= mem_rsp_rdata;
      if (cap_w1) w1_q <= mem_rsp_rdata;
    end
  end

  // Memory port
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = ent_addr;
    mem_req_wdata = '0;
    mem_req_wstrb = '0;
    case (st_q)
      ST_RD0: mem_req_valid = 1'b1;
      ST_RD1: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = ent_addr + AW'(WORD_BYTES);
      end
      ST_WR_R, ST_WR_C: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_addr  = ent_addr + AW'(WORD_BYTES);
        mem_req_wdata = wb_data;
        mem_req_wstrb = wb_strb;
      end
      default: ;
    endcase
  end

  // Result
  assign req_ready = (st_q == ST_IDLE);
  assign rsp_valid = (st_q == ST_DONE);
  assign rsp_hit   = hit_q;
  assign rsp_w0    = w0_q;
  assign rsp_w1    = w1_q;
  assign rsp_off   = ent_off;
  assign rsp_raddr = {w1_q[AW-1:PAGE_BITS], pofs_q};

endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk #(
  parameter int AW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic            mem_req_we,
  input logic [AW-1:0]   mem_req_addr,
  input logic [AW/8-1:0] mem_req_wstrb,
  input logic            mem_rsp_valid,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [AW-1:0]   rsp_w0
);

  // Tracks a read accepted on the port and not yet answered
  logic rd_open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_open_q <= 1'b0;
    else if (mem_rsp_valid) rd_open_q <= 1'b0;
    else if (mem_req_valid && mem_req_ready && !mem_req_we) rd_open_q <= 1'b1;
  end

  // R11: no new request while a read is still outstanding
  a_r11_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_open_q |-> !mem_req_valid);

  // R11: a stalled request keeps its address and kind
  a_r11_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

  // R7: each write touches exactly one byte lane
  a_r7_single_byte: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> $countones(mem_req_wstrb) == 1);

  // R10: an idle walker is silent on both sides
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !rsp_valid);

  // R10: a taken request makes the walker busy
  a_r10_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && req_valid |=> !req_ready);

  // R12: result is a single-cycle pulse, then idle
  a_r12_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  // R4: a reported hit carries a valid entry
  a_r4_hit_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> rsp_w0[AW-1]);

endmodule

bind hpt_walker hpt_walker_chk #(.AW(AW)) u_chk (.*);

// File: tb/hpt_walker_bench.sv
`timescale 1ns/1ps
module hpt_walker_bench;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [23:0] req_vsid;
  logic [31:0] req_ea;
  logic        req_store;
  logic [31:0] cfg_tbl_base;
  logic [31:0] cfg_tbl_mask;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic        mem_req_we;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic [3:0]  mem_req_wstrb;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [31:0] rsp_w0, rsp_w1, rsp_off, rsp_raddr;

  hpt_walker u_hpt_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vsid(req_vsid),
    .req_ea(req_ea), .req_store(req_store),
    .cfg_tbl_base(cfg_tbl_base), .cfg_tbl_mask(cfg_tbl_mask),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_wstrb(mem_req_wstrb),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_w0(rsp_w0), .rsp_w1(rsp_w1),
    .rsp_off(rsp_off), .rsp_raddr(rsp_raddr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Memory model: 4 KiB, one-cycle read latency, optional back-pressure
  logic [31:0] mem [1024];
  logic        rd_pend;
  logic [9:0]  rd_idx;
  logic [7:0]  stall_cnt;
  logic        stall_on;
  logic        tb_we, tb_clr;
  logic [9:0]  tb_idx;
  logic [31:0] tb_data;
  int          log_n;
  logic [31:0] log_addr [64];
  logic        log_we   [64];
  logic [3:0]  log_strb [64];
  logic [31:0] log_wd   [64];

  assign mem_req_ready = stall_on ? stall_cnt[0] : 1'b1;

  always @(posedge clk) begin
    stall_cnt     <= stall_cnt + 8'd1;
    mem_rsp_valid <= 1'b0;
    if (rd_pend) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_rdata <= mem[rd_idx];
      rd_pend       <= 1'b0;
    end
    if (tb_clr) begin
      for (int k = 0; k < 1024; k++) mem[k] <= 32'h0;
    end else if (tb_we) begin
      mem[tb_idx] <= tb_data;
    end
    if (mem_req_valid && mem_req_ready) begin
      if (log_n < 64) begin
        log_addr[log_n] <= mem_req_addr;
        log_we[log_n]   <= mem_req_we;
        log_strb[log_n] <= mem_req_wstrb;
        log_wd[log_n]   <= mem_req_wdata;
      end
      log_n <= log_n + 1;
      if (mem_req_we) begin
        for (int k = 0; k < 4; k++)
          if (mem_req_wstrb[k]) mem[mem_req_addr[11:2]][8*k +: 8] <= mem_req_wdata[8*k +: 8];
      end else begin
        rd_pend <= 1'b1;
        rd_idx  <= mem_req_addr[11:2];
      end
    end
  end

  // Reference formulas taken from the requirements
  function automatic logic [31:0] f_goff(input logic [23:0] v, input logic [31:0] ea,
                                         input bit sec, input logic [31:0] mask);
    logic [31:0] h;
    h = {8'h0, v} ^ {16'h0, ea[27:12]};
    if (sec) h = ~h;
    return (h << 6) & mask;
  endfunction

  function automatic logic [31:0] f_tag(input logic [23:0] v, input logic [31:0] ea);
    return ({8'h0, v} << 7) | {26'h0, ea[27:22]};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk);
    tb_we = 1'b1; tb_idx = addr[11:2]; tb_data = data;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic clear_mem();
    @(negedge clk); tb_clr = 1'b1;
    @(negedge clk); tb_clr = 1'b0;
  endtask

  logic        g_hit;
  logic [31:0] g_w0, g_w1, g_off, g_raddr;
  int          g_log0;
  int          g_busy_bad;

  // Issues a walk; with `compete` set, keeps a rival request asserted while busy
  task automatic walk(input logic [23:0] v, input logic [31:0] ea, input bit st, input bit compete);
    int n;
    g_log0 = log_n;
    g_busy_bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vsid = v; req_ea = ea; req_store = st;
    @(negedge clk);
    if (compete) begin
      req_vsid = v ^ 24'h5A5A5A; req_ea = ea ^ 32'h0F0F_F000;
    end else begin
      req_valid = 1'b0;
    end
    n = 0;
    while (!rsp_valid && n < 2000) begin
      if (req_ready) g_busy_bad++;
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    if (!rsp_valid) begin
      checks++; errors++;
      $display("FAIL R12 walk timeout act=0 exp=1");
    end
    g_hit = rsp_hit; g_w0 = rsp_w0; g_w1 = rsp_w1; g_off = rsp_off; g_raddr = rsp_raddr;
    @(negedge clk);
    chk("R12 ready after pulse", {31'h0, req_ready}, 32'h1);
    chk("R12 pulse one cycle", {31'h0, rsp_valid}, 32'h0);
  endtask

  task automatic t_reset();
    chk("R1 req_ready", {31'h0, req_ready}, 32'h1);
    chk("R1 mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
    chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
  endtask

  // Primary hit after near-miss entries, load, referenced bit clear
  task automatic t_primary();
    logic [23:0] v; logic [31:0] ea, go, tg, e3;
    v = 24'h012345; ea = 32'h0ABC_D123;
    clear_mem();
    go = f_goff(v, ea, 1'b0, cfg_tbl_mask); tg = f_tag(v, ea);
    put(go + 0,  (tg ^ 32'h0000_0080) | 32'h8000_0000);
    put(go + 8,  tg | 32'h8000_0040);
    put(go + 16, tg);
    put(go + 24, tg | 32'h8000_0000);
    put(go + 28, 32'h55AA_5002);
    e3 = go + 24;
    walk(v, ea, 1'b0, 1'b0);
    chk("R4 primary hit", {31'h0, g_hit}, 32'h1);
    chk("R6 w0", g_w0, tg | 32'h8000_0000);
    chk("R6 w1", g_w1, 32'h55AA_5002);
    chk("R6 offset", g_off, e3);
    chk("R6 raddr", g_raddr, 32'h55AA_5123);
    chk("R5 access count", log_n - g_log0, 6);
    chk("R2 first read addr", log_addr[g_log0], go);
    chk("R5 word0 before word1", log_addr[g_log0 + 3], e3);
    chk("R5 word1 addr", log_addr[g_log0 + 4], e3 + 4);
    chk("R7 write strobe", {28'h0, log_strb[g_log0 + 5]}, 32'h2);
    chk("R7 write lane", {24'h0, log_wd[g_log0 + 5][15:8]}, 32'h51);
    chk("R7 memory after", mem[(e3 + 4) >> 2], 32'h55AA_5102);
  endtask

  // Secondary hit, store with both status bits clear
  task automatic t_secondary();
    logic [23:0] v; logic [31:0] ea, gp, gs, tg, e5;
    v = 24'h0F00F0; ea = 32'h3123_4ABC;
    clear_mem();
    gp = f_goff(v, ea, 1'b0, cfg_tbl_mask); gs = f_goff(v, ea, 1'b1, cfg_tbl_mask);
    tg = f_tag(v, ea);
    for (int s = 0; s < 8; s++) begin
      if (s == 4) put(gp + 32, tg | 32'h8000_0040);
      else        put(gp + 8 * s, (tg ^ (32'h80 << s)) | 32'h8000_0000);
    end
    put(gs + 0, tg | 32'h8000_0000);
    put(gs + 40, tg | 32'h8000_0040);
    put(gs + 44, 32'hCAFE_E003);
    e5 = gs + 40;
    walk(v, ea, 1'b1, 1'b0);
    chk("R3 secondary hit", {31'h0, g_hit}, 32'h1);
    chk("R3 offset", g_off, e5);
    chk("R6 raddr", g_raddr, 32'hCAFE_EABC);
    chk("R5 access count", log_n - g_log0, 17);
    chk("R3 first secondary read", log_addr[g_log0 + 8], gs);
    chk("R7 ref write first", {28'h0, log_strb[g_log0 + 15]}, 32'h2);
    chk("R8 chg write second", {28'h0, log_strb[g_log0 + 16]}, 32'h1);
    chk("R8 chg lane", {24'h0, log_wd[g_log0 + 16][7:0]}, 32'h83);
    chk("R8 memory after", mem[(e5 + 4) >> 2], 32'hCAFE_E183);
  endtask

  // Status bits already set or load with changed clear: no writes
  task automatic t_no_write();
    logic [23:0] v; logic [31:0] ea, go, tg;
    v = 24'h00BEEF; ea = 32'h0000_1FFF;
    clear_mem();
    go = f_goff(v, ea, 1'b0, cfg_tbl_mask); tg = f_tag(v, ea);
    put(go, tg | 32'h8000_0000);
    put(go + 4, 32'h1234_5182);
    walk(v, ea, 1'b1, 1'b0);
    chk("R8 store bits set hit", {31'h0, g_hit}, 32'h1);
    chk("R8 store bits set no write", log_n - g_log0, 2);
    put(go + 4, 32'h1234_5102);
    walk(v, ea, 1'b0, 1'b0);
    chk("R8 load chg clear no write", log_n - g_log0, 2);
    chk("R8 load memory intact", mem[(go + 4) >> 2], 32'h1234_5102);
  endtask

  // Empty table: miss after sixteen reads
  task automatic t_miss();
    logic [23:0] v; logic [31:0] ea, go, gs;
    v = 24'h777000; ea = 32'h0FFF_F000;
    clear_mem();
    go = f_goff(v, ea, 1'b0, cfg_tbl_mask); gs = f_goff(v, ea, 1'b1, cfg_tbl_mask);
    walk(v, ea, 1'b1, 1'b0);
    chk("R9 miss", {31'h0, g_hit}, 32'h0);
    chk("R9 read count", log_n - g_log0, 16);
    chk("R9 last read", log_addr[g_log0 + 15], gs + 56);
    chk("R9 memory untouched", mem[(go + 4) >> 2], 32'h0);
  endtask

  // Back-pressure plus a competing request held during the walk
  task automatic t_busy();
    logic [23:0] v; logic [31:0] ea, go, tg;
    int extra;
    v = 24'h00C0DE; ea = 32'h0246_8ACE;
    clear_mem();
    go = f_goff(v, ea, 1'b0, cfg_tbl_mask); tg = f_tag(v, ea);
    put(go + 16, tg | 32'h8000_0000);
    put(go + 20, 32'hABCD_E1FF);
    stall_on = 1'b1;
    walk(v, ea, 1'b0, 1'b1);
    chk("R10 busy ready low", g_busy_bad, 0);
    chk("R11 stalled walk raddr", g_raddr, 32'hABCD_EACE);
    chk("R11 stalled walk offset", g_off, go + 16);
    extra = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (rsp_valid || mem_req_valid) extra++;
    end
    chk("R10 rival request ignored", extra, 0);
    stall_on = 1'b0;
  endtask

  // Narrow mask on non-zero base
  task automatic t_mask();
    logic [23:0] v; logic [31:0] ea, go, tg;
    cfg_tbl_base = 32'h0000_0800; cfg_tbl_mask = 32'h0000_03C0;
    v = 24'hABCDEF; ea = 32'h0765_4321;
    clear_mem();
    go = f_goff(v, ea, 1'b0, cfg_tbl_mask); tg = f_tag(v, ea);
    put(32'h800 + go + 56, tg | 32'h8000_0000);
    put(32'h800 + go + 60, 32'h0F0F_0100);
    walk(v, ea, 1'b0, 1'b0);
    chk("R2 mask hit", {31'h0, g_hit}, 32'h1);
    chk("R2 first read with base", log_addr[g_log0], 32'h800 + go);
    chk("R6 offset excludes base", g_off, go + 56);
    chk("R6 raddr", g_raddr, 32'h0F0F_0321);
    chk("R5 access count", log_n - g_log0, 9);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vsid = '0; req_ea = '0; req_store = 1'b0;
    cfg_tbl_base = 32'h0; cfg_tbl_mask = 32'h0000_0FC0;
    tb_we = 1'b0; tb_clr = 1'b0; tb_idx = '0; tb_data = '0; stall_on = 1'b0;
    stall_cnt = '0; rd_pend = 1'b0; rd_idx = '0; log_n = 0;
    mem_rsp_valid = 1'b0; mem_rsp_rdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_primary();
    t_secondary();
    t_no_write();
    t_miss();
    t_busy();
    t_mask();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R12 watchdog act=expired exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule